// File: doc/BRIEF.md
# Fractional-Nanosecond Time Counter

This block keeps the time of day for a timestamping subsystem. On every core clock cycle while it is running, it adds a programmable step to a wide time accumulator. The step is a 32.32 fixed-point count of nanoseconds, so the fractional part builds up exactly and carries into whole nanoseconds. Software trims the frequency by rewriting the step. The counter keeps running and does not restart when the step changes.

Software reaches the block through a small register port. It has a write strobe, a read strobe, an address and 64-bit data. Read data comes back with a fixed latency of one cycle. The configuration register at 0xF00 holds the run enable. The fraction word is at 0xF08, the nanosecond word at 0xF10 and the step at 0xF18. Software can write both time words to set the clock. For a core clock of F Hz, the nominal step is (10^9 · 2^32) / F.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, the configuration, fraction, nanosecond and step registers all read as zero.
- R2: Bit 0 of the register at 0xF00 enables counting. While it is 0, the time accumulator keeps its value. A read of 0xF00 returns the enable in bit 0, and zeros in all other bits.
- R3: While enabled, the 64-bit step is added once per cycle to a 96-bit accumulator. Step bits 31:0 add to the fraction and step bits 63:32 add to whole nanoseconds. A carry out of the fraction increments the nanosecond count.
- R4: A read of 0xF10 returns the 64-bit nanosecond count. A read of 0xF08 returns the 32-bit fraction in bits 31:0, and zeros in bits 63:32.
- R5: A step written to 0xF18 is used from the cycle after the write. The increment in the cycle of the write still uses the old step, and the accumulated time is kept.
- R6: A write to 0xF10 loads the nanosecond count, and a write to 0xF08 loads the fraction from wdata bits 31:0. In that cycle no increment is applied and the other time field holds its value.
- R7: Every read strobe gives exactly one rvalid pulse on the next cycle, carrying the register value from before that clock edge. When there is no read, rvalid stays low.
- R8: A read of any address other than the four registers returns zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The hardest cases to reach from the ports are the ones that depend on the exact cycle: how many increments land between an enable and a disable, and which step applies in the cycle where the step is rewritten. The stimulus drives back-to-back register writes with a known number of idle cycles between them. That produces a known count of increments, with the step change in the middle, and the resulting totals are compared with literal values. A separate run starts just below a 32-bit boundary of the nanosecond count, with a fraction that is already half full. This forces fraction carries and a carry across the word boundary within a few cycles.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_FRAC,
    SEL_NS,
    SEL_STEP
  } reg_sel_e;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-1:0] OFS_CFG  = 12'hF00,
  parameter logic [ADDR_W-1:0] OFS_FRAC = 12'hF08,
  parameter logic [ADDR_W-1:0] OFS_NS   = 12'hF10,
  parameter logic [ADDR_W-1:0] OFS_STEP = 12'hF18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output reg_sel_e          sel,
  output logic              run_en,
  output logic [DATA_W-1:0] step,
  output logic              load_frac,
  output logic              load_ns
);

  always_comb begin
    if (addr == OFS_CFG)       sel = SEL_CFG;
    else if (addr == OFS_FRAC) sel = SEL_FRAC;
    else if (addr == OFS_NS)   sel = SEL_NS;
    else if (addr == OFS_STEP) sel = SEL_STEP;
    else                       sel = SEL_NONE;
  end

  assign load_frac = wr_en && (sel == SEL_FRAC);
  assign load_ns   = wr_en && (sel == SEL_NS);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en <= 1'b0;
      step   <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CFG)  run_en <= wdata[0];
      if (sel == SEL_STEP) step   <= wdata;
    end
  end

  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_STEP) |=> (step == $past(wdata))); // R5
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_NONE) |=> ($stable(step) && $stable(run_en))); // R8

endmodule

// File: rtl/ptp_tc_accum.sv
module ptp_tc_accum #(
  parameter int DATA_W = 64,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [DATA_W-1:0] step,
  input  logic              load_frac,
  input  logic              load_ns,
  input  logic [DATA_W-1:0] wdata,
  output logic [NS_W-1:0]   ns,
  output logic [FRAC_W-1:0] frac
);
  localparam int ACC_W = NS_W + FRAC_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step_ext;

  assign step_ext = ACC_W'(step);
  assign ns       = acc[ACC_W-1:FRAC_W];
  assign frac     = acc[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (load_ns || load_frac) begin
      if (load_ns)   acc[ACC_W-1:FRAC_W] <= wdata[NS_W-1:0];
      if (load_frac) acc[FRAC_W-1:0]     <= wdata[FRAC_W-1:0];
    end else if (run_en) begin
      acc <= acc + step_ext;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !load_ns && !load_frac) |=> $stable(acc)); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (run_en && !load_ns && !load_frac) |=> (acc == $past(acc) + $past(step_ext))); // R3
  AST_NS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load_ns && !load_frac) |=> (ns == $past(wdata[NS_W-1:0]) && $stable(frac))); // R6

endmodule

// File: rtl/ptp_tc_rdport.sv
module ptp_tc_rdport
  import ptp_tc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic              run_en,
  input  logic [NS_W-1:0]   ns,
  input  logic [FRAC_W-1:0] frac,
  input  logic [DATA_W-1:0] step,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (sel)
      SEL_CFG:  rd_mux = DATA_W'(run_en);
      SEL_FRAC: rd_mux = DATA_W'(frac);
      SEL_NS:   rd_mux = DATA_W'(ns);
      SEL_STEP: rd_mux = step;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> (rdata == '0)); // R8

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  parameter int NS_W   = 64,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  reg_sel_e          sel;
  logic              run_en;
  logic [DATA_W-1:0] step;
  logic              load_frac;
  logic              load_ns;
  logic [NS_W-1:0]   ns;
  logic [FRAC_W-1:0] frac;

  ptp_tc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sel(sel), .run_en(run_en), .step(step),
    .load_frac(load_frac), .load_ns(load_ns)
  );

  ptp_tc_accum #(.DATA_W(DATA_W), .NS_W(NS_W), .FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst(rst), .run_en(run_en), .step(step),
    .load_frac(load_frac), .load_ns(load_ns), .wdata(wdata),
    .ns(ns), .frac(frac)
  );

  ptp_tc_rdport #(.DATA_W(DATA_W), .NS_W(NS_W), .FRAC_W(FRAC_W)) u_rdport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .run_en(run_en),
    .ns(ns), .frac(frac), .step(step), .rdata(rdata), .rvalid(rvalid)
  );

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid); // R7

endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  localparam logic [11:0] A_CFG  = 12'hF00;
  localparam logic [11:0] A_FRAC = 12'hF08;
  localparam logic [11:0] A_NS   = 12'hF10;
  localparam logic [11:0] A_STEP = 12'hF18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        rvalid;

  int checks = 0;
  int errors = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  // reference state, built from the requirements
  logic        m_en   = 1'b0;
  logic [63:0] m_step = '0;
  logic [95:0] m_acc  = '0;

  always #2.5 clk = ~clk;

  ptp_time_counter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 1'b0; m_step <= '0; m_acc <= '0;
    end else if (wr_en && (addr == A_NS || addr == A_FRAC)) begin
      if (addr == A_NS) m_acc[95:32] <= wdata;
      else              m_acc[31:0]  <= wdata[31:0];
    end else begin
      if (m_en) m_acc <= m_acc + {32'b0, m_step};
      if (wr_en && addr == A_CFG)  m_en   <= wdata[0];
      if (wr_en && addr == A_STEP) m_step <= wdata;
    end
  end

  function automatic logic [63:0] model_val(logic [11:0] a);
    case (a)
      A_CFG:  return {63'b0, m_en};
      A_FRAC: return {32'b0, m_acc[31:0]};
      A_NS:   return m_acc[95:32];
      A_STEP: return m_step;
      default: return 64'b0;
    endcase
  endfunction

  // monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: rvalid without read, actual %h expected none", rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [63:0] e, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_model(input logic [11:0] a, input string tag);
    rd_exp(a, model_val(a), tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd_exp(A_CFG,  64'h0, "R1 cfg");
    rd_exp(A_FRAC, 64'h0, "R1 frac");
    rd_exp(A_NS,   64'h0, "R1 ns");
    rd_exp(A_STEP, 64'h0, "R1 step");

    // R2 disabled with a step loaded: time holds
    wr(A_STEP, 64'h0000_0001_4000_0000);
    idle(5);
    rd_exp(A_NS, 64'h0, "R2 hold while off");
    rd_exp(A_STEP, 64'h0000_0001_4000_0000, "R5 step readback");

    // R3 exact 4 increments of 0.5 ns -> 2.0 ns
    wr(A_STEP, 64'h0000_0000_8000_0000);
    wr(A_CFG, 64'h1);
    idle(3);
    wr(A_CFG, 64'h0);
    rd_exp(A_NS,   64'd2, "R3 ns after 4 half steps");
    rd_exp(A_FRAC, 64'h0, "R3 frac after 4 half steps");
    rd_exp(A_CFG,  64'h0, "R2 cfg readback");
    idle(4);
    rd_exp(A_NS,   64'd2, "R2 hold after disable");

    // R5 step change mid-run: 1+1+3+3 = 8 ns
    wr(A_STEP, 64'h0000_0001_0000_0000);
    wr(A_NS, 64'h0);
    wr(A_FRAC, 64'h0);
    wr(A_CFG, 64'h1);
    idle(1);
    wr(A_STEP, 64'h0000_0003_0000_0000);
    idle(1);
    wr(A_CFG, 64'h0);
    rd_exp(A_NS, 64'd8, "R5 step switch timing");

    // R6 load while running: no increment in the load cycle
    wr(A_STEP, 64'h0000_0001_4000_0000);
    wr(A_CFG, 64'h1);
    idle(3);
    wr(A_NS, 64'd1000);
    rd_exp(A_NS, 64'd1000, "R6 ns load priority");
    rd_model(A_FRAC, "R6 frac kept across ns load");
    idle(2);
    rd_model(A_NS, "R3 running ns");
    wr(A_FRAC, 64'hFFFF_FFFF_1234_5678);
    rd_exp(A_FRAC, 64'h0000_0000_1234_5678, "R4 frac upper bits zero");
    wr(A_CFG, 64'h0);

    // R3 fraction carry and 32-bit word carry in the ns count
    wr(A_NS, 64'h0000_0000_FFFF_FFFE);
    wr(A_FRAC, 64'h8000_0000);
    wr(A_STEP, 64'h0000_0001_C000_0000);
    wr(A_CFG, 64'h1);
    for (int i = 0; i < 4; i++) rd_model(A_NS, "R3 carry run ns");
    wr(A_CFG, 64'h0);
    rd_model(A_NS, "R4 ns wide count");
    rd_model(A_FRAC, "R4 frac wide count");

    // R8 unmapped address
    rd_exp(12'h100, 64'h0, "R8 unmapped read");
    wr(12'hF20, 64'hDEAD_BEEF_0000_0001);
    wr(12'h0F0, 64'h1);
    rd_model(A_STEP, "R8 step untouched");
    rd_model(A_CFG,  "R8 cfg untouched");
    rd_model(A_NS,   "R8 ns untouched");

    // R7 back-to-back reads, then idle must give no data
    rd_model(A_NS, "R7 back-to-back 1");
    rd_model(A_FRAC, "R7 back-to-back 2");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7: actual %0d reads unanswered expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule